// File: doc/BRIEF.md
# Packed SIMD Absolute-Value Unit

This block computes absolute values over a packed vector operand, or over a single scalar floating-point value. In vector mode the operand is one 64-bit register or a pair of them (quad mode, 128 bits). The lanes are read as signed two's-complement integers of 8, 16 or 32 bits, or as half- or single-precision floats. In scalar mode the low bits of the operand hold one half-, single- or double-precision float. An integer lane gets a wraparound absolute value, truncated to the lane width. A float lane only has its sign bit cleared, so NaN and infinity encodings keep their exponent and mantissa.

The unit also checks whether the requested combination is legal. It looks at the size code, the float, quad and scalar flags, a strap that says half precision is supported, and the low bits of the source and destination register numbers. An illegal request raises an undefined-operation flag and returns an all-zero result. Every request gives a registered result exactly one clock after it is accepted, whatever the operand data. The register file, condition evaluation and trapping are handled outside the block.

Top module: `simd_abs_unit`

## Requirements
- R1: Every cycle with `in_valid` high gives `out_valid` high on the following cycle only. `out_valid` is low in every other cycle. Reset clears `out_valid`, `out_undef` and `out_result`. The one-cycle latency is the same for every operand value.
- R2: In vector mode, `in_size` 00 selects 8-bit lanes, 01 selects 16-bit lanes and 10 selects 32-bit lanes. Size 11 is undefined in vector mode.
- R3: In vector mode with `in_float`=1, size 00 is undefined. Size 01 (half precision) is undefined when `in_fp16_ok`=0 and legal when it is 1.
- R4: In vector mode with `in_quad`=1, the request is undefined if bit 0 of `in_src` or of `in_dst` is 1. In scalar mode, `in_quad`, `in_src` and `in_dst` have no effect.
- R5: An integer lane returns the low lane-width bits of the absolute value of its signed value. The most negative value (for example 0x80 in an 8-bit lane) returns itself.
- R6: A floating-point lane has its top bit (bit 15 of a 16-bit lane, bit 31 of a 32-bit lane) forced to 0. All other bits pass through unchanged, including negative zero, infinity and NaN patterns.
- R7: A legal vector request without quad processes bits 63:0, and `out_result[127:64]` is zero. With quad, both 64-bit halves are processed.
- R8: In scalar mode (`in_scalar`=1, always floating point), sizes behave as follows. Size 00 is undefined. Size 01 is undefined without `in_fp16_ok`; when legal, it gives the sign-cleared bits 15:0 with bits 127:16 zero. Size 10 gives the sign-cleared bits 31:0 with the upper bits zero. Size 11 gives the sign-cleared bits 63:0 with the upper bits zero.
- R9: An undefined request produces `out_undef`=1 together with `out_valid` and an all-zero `out_result`. A legal request produces `out_undef`=0.
- R10: `out_result` and `out_undef` load only on a cycle with `in_valid` high. Otherwise they hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one request per cycle |
| in_opnd | input | 128 | Operand; bits 63:0 are the first register, 127:64 the second |
| in_size | input | 2 | Lane size code |
| in_float | input | 1 | Vector lanes are floating point |
| in_quad | input | 1 | Vector spans two registers |
| in_scalar | input | 1 | Single scalar floating-point operation |
| in_fp16_ok | input | 1 | Half-precision support strap |
| in_src | input | 5 | Source register number |
| in_dst | input | 5 | Destination register number |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_undef | output | 1 | Last accepted request was illegal |
| out_result | output | 128 | Result of the last accepted request |

## Verification
Every request's result, undefined flag and valid strobe are due in the cycle after the clock edge that accepts it. The bench drives a request on a falling edge and drops `in_valid` on the next falling edge, where it samples all three outputs. One cycle later it checks that the strobe is low and that the result and flag have held, even though the operand lines were changed in between. Expected values come from a lane-by-lane reference function in the bench. The stimulus is random with a fixed seed, plus directed cases for the most negative integers, negative zero, NaN, infinity and every illegal size, float and quad combination.

// File: rtl/simd_abs_pkg.sv
package simd_abs_pkg;

    localparam int VEC_BITS   = 128;
    localparam int HALF_BITS  = 64;
    localparam int NUM_HALVES = VEC_BITS / HALF_BITS;
    localparam int NUM_SIZES  = 4;

    typedef enum logic [1:0] {
        SZ_B8  = 2'b00,
        SZ_H16 = 2'b01,
        SZ_W32 = 2'b10,
        SZ_D64 = 2'b11
    } lane_sz_e;

    typedef struct packed {
        logic     undef;
        logic     is_scalar;
        logic     is_float;
        logic     use_high;
        lane_sz_e size;
    } abs_ctl_t;

    // Lane width in bits for a size code.
    function automatic int lane_bits(lane_sz_e s);
        return 8 << int'(s);
    endfunction

    // True when a float size code is not usable.
    function automatic logic fp_size_bad(lane_sz_e s, logic fp16_ok);
        return (s == SZ_B8) || ((s == SZ_H16) && !fp16_ok);
    endfunction

    // Mask keeping the low lane_bits(s) bits of a scalar result.
    function automatic logic [VEC_BITS-1:0] scalar_keep(lane_sz_e s);
        logic [VEC_BITS-1:0] m;
        int w;
        w = lane_bits(s);
        for (int i = 0; i < VEC_BITS; i++) begin
            m[i] = (i < w);
        end
        return m;
    endfunction

endpackage

// File: rtl/simd_abs_decode.sv
module simd_abs_decode
    import simd_abs_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  lane_sz_e         size,
    input  logic             flt,
    input  logic             quad,
    input  logic             scal,
    input  logic             fp16_ok,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    output abs_ctl_t         ctl
);

    logic vec_bad;
    logic scal_bad;
    logic pair_misaligned;

    assign pair_misaligned = quad && (src[0] || dst[0]);

    always_comb begin
        vec_bad = 1'b0;
        if (size == SZ_D64) begin
            vec_bad = 1'b1;
        end
        if (flt && fp_size_bad(size, fp16_ok)) begin
            vec_bad = 1'b1;
        end
        if (pair_misaligned) begin
            vec_bad = 1'b1;
        end
    end

    assign scal_bad = fp_size_bad(size, fp16_ok);

    always_comb begin
        ctl.undef     = scal ? scal_bad : vec_bad;
        ctl.is_scalar = scal;
        ctl.is_float  = scal | flt;
        ctl.use_high  = !scal && quad;
        ctl.size      = size;
    end

endmodule

// File: rtl/simd_abs_int_half.sv
module simd_abs_int_half
    import simd_abs_pkg::*;
#(
    parameter int HALF_W = 64
) (
    input  logic [HALF_W-1:0] x,
    input  lane_sz_e          size,
    output logic [HALF_W-1:0] y
);

    localparam int INT_SIZES = 3;

    for (genvar g = 0; g < INT_SIZES; g++) begin : g_w
        localparam int W = 8 << g;
        localparam int N = HALF_W / W;
        logic [HALF_W-1:0] r;
        for (genvar l = 0; l < N; l++) begin : g_l
            logic [W-1:0] v;
            assign v = x[l*W +: W];
            // Two's-complement negate when negative; the minimum wraps to itself.
            assign r[l*W +: W] = v[W-1] ? (~v + W'(1)) : v;
        end
    end

    always_comb begin
        case (size)
            SZ_B8:   y = g_w[0].r;
            SZ_H16:  y = g_w[1].r;
            SZ_W32:  y = g_w[2].r;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_abs_fp_half.sv
module simd_abs_fp_half
    import simd_abs_pkg::*;
#(
    parameter int HALF_W = 64
) (
    input  logic [HALF_W-1:0] x,
    input  lane_sz_e          size,
    output logic [HALF_W-1:0] y
);

    // Float formats: 16, 32 and 64 bits (index 1..3 of the size code).
    for (genvar g = 1; g < NUM_SIZES; g++) begin : g_w
        localparam int W = 8 << g;
        logic [HALF_W-1:0] r;
        for (genvar b = 0; b < HALF_W; b++) begin : g_b
            if ((b % W) == (W - 1)) begin : g_sign
                assign r[b] = 1'b0;
            end else begin : g_pass
                assign r[b] = x[b];
            end
        end
    end

    always_comb begin
        case (size)
            SZ_H16:  y = g_w[1].r;
            SZ_W32:  y = g_w[2].r;
            SZ_D64:  y = g_w[3].r;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_abs_unit.sv
module simd_abs_unit
    import simd_abs_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [VEC_BITS-1:0] in_opnd,
    input  logic [1:0]          in_size,
    input  logic                in_float,
    input  logic                in_quad,
    input  logic                in_scalar,
    input  logic                in_fp16_ok,
    input  logic [REG_W-1:0]    in_src,
    input  logic [REG_W-1:0]    in_dst,
    output logic                out_valid,
    output logic                out_undef,
    output logic [VEC_BITS-1:0] out_result
);

    lane_sz_e            sz;
    abs_ctl_t            ctl;
    logic [VEC_BITS-1:0] int_res;
    logic [VEC_BITS-1:0] fp_res;
    logic [VEC_BITS-1:0] nxt;

    assign sz = lane_sz_e'(in_size);

    simd_abs_decode #(.REG_W(REG_W)) u_decode (
        .size    (sz),
        .flt     (in_float),
        .quad    (in_quad),
        .scal    (in_scalar),
        .fp16_ok (in_fp16_ok),
        .src     (in_src),
        .dst     (in_dst),
        .ctl     (ctl)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        simd_abs_int_half #(.HALF_W(HALF_BITS)) u_int (
            .x    (in_opnd[h*HALF_BITS +: HALF_BITS]),
            .size (sz),
            .y    (int_res[h*HALF_BITS +: HALF_BITS])
        );
        simd_abs_fp_half #(.HALF_W(HALF_BITS)) u_fp (
            .x    (in_opnd[h*HALF_BITS +: HALF_BITS]),
            .size (sz),
            .y    (fp_res[h*HALF_BITS +: HALF_BITS])
        );
    end

    always_comb begin
        nxt = '0;
        if (!ctl.undef) begin
            if (ctl.is_scalar) begin
                nxt = fp_res & scalar_keep(ctl.size);
            end else begin
                for (int h = 0; h < NUM_HALVES; h++) begin
                    if (h == 0 || ctl.use_high) begin
                        nxt[h*HALF_BITS +: HALF_BITS] = ctl.is_float
                            ? fp_res[h*HALF_BITS +: HALF_BITS]
                            : int_res[h*HALF_BITS +: HALF_BITS];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_undef  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_undef  <= ctl.undef;
                out_result <= nxt;
            end
        end
    end

endmodule

// File: rtl/simd_abs_chk.sv
module simd_abs_chk
    import simd_abs_pkg::*;
#(
    parameter int REG_W = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [VEC_BITS-1:0] in_opnd,
    input logic [1:0]          in_size,
    input logic                in_float,
    input logic                in_quad,
    input logic                in_scalar,
    input logic [REG_W-1:0]    in_src,
    input logic [REG_W-1:0]    in_dst,
    input logic                out_valid,
    input logic                out_undef,
    input logic [VEC_BITS-1:0] out_result
);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_size11_vec_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_scalar && in_size == 2'b11) |=> out_undef);

    assert_fp_byte_lane_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_scalar && in_float && in_size == 2'b00) |=> out_undef);

    assert_quad_odd_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_scalar && in_quad && (in_src[0] || in_dst[0])) |=> out_undef);

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_scalar && !in_quad) |=> (out_result[VEC_BITS-1:HALF_BITS] == '0));

    assert_scalar_single_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_scalar && in_size == 2'b10) |=>
            (!out_undef && !out_result[31] &&
             out_result[30:0] == $past(in_opnd[30:0]) &&
             out_result[VEC_BITS-1:32] == '0));

    assert_undef_zero_R9: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> (out_result == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_undef)));

endmodule

bind simd_abs_unit simd_abs_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_opnd    (in_opnd),
    .in_size    (in_size),
    .in_float   (in_float),
    .in_quad    (in_quad),
    .in_scalar  (in_scalar),
    .in_src     (in_src),
    .in_dst     (in_dst),
    .out_valid  (out_valid),
    .out_undef  (out_undef),
    .out_result (out_result)
);

// File: tb/tb_simd_abs_unit.sv
`timescale 1ns/1ps
module tb_simd_abs_unit;

    localparam int  RW     = 5;
    localparam time PERIOD = 20ns;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [127:0]  in_opnd;
    logic [1:0]    in_size;
    logic          in_float, in_quad, in_scalar, in_fp16_ok;
    logic [RW-1:0] in_src, in_dst;
    logic          out_valid, out_undef;
    logic [127:0]  out_result;

    int checks = 0;
    int bad    = 0;

    always #(PERIOD/2) clk = ~clk;

    simd_abs_unit #(.REG_W(RW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_opnd(in_opnd),
        .in_size(in_size), .in_float(in_float), .in_quad(in_quad),
        .in_scalar(in_scalar), .in_fp16_ok(in_fp16_ok), .in_src(in_src),
        .in_dst(in_dst), .out_valid(out_valid), .out_undef(out_undef),
        .out_result(out_result)
    );

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic ref_undef(logic [1:0] sz, logic flt, logic quad, logic scal,
                                       logic fp16, logic [RW-1:0] src, logic [RW-1:0] dst);
        logic fbad;
        fbad = (sz == 2'b00) || (sz == 2'b01 && !fp16);
        if (scal) return fbad;
        return (sz == 2'b11) || (flt && fbad) || (quad && (src[0] || dst[0]));
    endfunction

    function automatic logic [127:0] ref_result(logic [127:0] op, logic [1:0] sz, logic flt,
                                                logic quad, logic scal, logic undef);
        logic [127:0] r;
        int w;
        int span;
        r = '0;
        w = 8 << sz;
        if (undef) return r;
        if (scal) begin
            for (int i = 0; i < w - 1; i++) r[i] = op[i];
            return r;
        end
        span = quad ? 128 : 64;
        for (int e = 0; e < span / w; e++) begin
            logic [63:0] v;
            logic [63:0] lim;
            v   = '0;
            lim = (64'd1 << w);
            for (int b = 0; b < w; b++) v[b] = op[e*w + b];
            if (flt) v[w-1] = 1'b0;
            else if (v[w-1]) v = (lim - v) & (lim - 64'd1);
            for (int b = 0; b < w; b++) r[e*w + b] = v[b];
        end
        return r;
    endfunction

    task automatic run_op(string tag, logic [127:0] op, logic [1:0] sz, logic flt, logic quad,
                          logic scal, logic fp16, logic [RW-1:0] src, logic [RW-1:0] dst);
        logic         eu;
        logic [127:0] er;
        eu = ref_undef(sz, flt, quad, scal, fp16, src, dst);
        er = ref_result(op, sz, flt, quad, scal, eu);
        @(negedge clk);
        in_valid = 1'b1; in_opnd = op; in_size = sz; in_float = flt; in_quad = quad;
        in_scalar = scal; in_fp16_ok = fp16; in_src = src; in_dst = dst;
        @(negedge clk);
        in_valid = 1'b0;
        in_opnd  = ~op;
        in_size  = sz + 2'd1;
        check({tag, " R1 valid"}, {127'd0, out_valid}, 128'd1);
        check({tag, " R9 undef"}, {127'd0, out_undef}, {127'd0, eu});
        check({tag, " result"}, out_result, er);
        @(negedge clk);
        check({tag, " R1 idle valid"}, {127'd0, out_valid}, 128'd0);
        check({tag, " R10 hold"}, out_result, er);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_opnd = '1; in_size = 2'b00;
        in_float = 1'b0; in_quad = 1'b0; in_scalar = 1'b0; in_fp16_ok = 1'b0;
        in_src = '0; in_dst = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {127'd0, out_valid}, 128'd0);
        check("R1 reset undef", {127'd0, out_undef}, 128'd0);
        check("R1 reset result", out_result, 128'd0);
        rst = 1'b0;

        // R5 integer corner lanes
        run_op("R5 int8 min", {64'hFFFF, 64'h80FF_7F00_8001_FE80}, 2'b00, 0, 0, 0, 0, 5'd2, 5'd4);
        run_op("R5 int16 min", {64'h0, 64'h8000_FFFF_7FFF_8001}, 2'b01, 0, 0, 0, 0, 5'd1, 5'd3);
        run_op("R5 int32 min quad", {64'h8000_0000_FFFF_FFFE, 64'h7FFF_FFFF_8000_0000},
               2'b10, 0, 1, 0, 0, 5'd2, 5'd6);
        // R6 float corners: -0, NaN, -inf
        run_op("R6 f32 neg zero NaN", {64'h0, 64'h8000_0000_FFC0_0000}, 2'b10, 1, 0, 0, 0, 5'd0, 5'd0);
        run_op("R6 f32 neg inf quad", {64'hFF80_0000_7F80_0001, 64'hBF80_0000_0000_0000},
               2'b10, 1, 1, 0, 0, 5'd4, 5'd8);
        run_op("R6 R3 f16 legal", {64'h0, 64'h8000_FC00_FE01_BC00}, 2'b01, 1, 0, 0, 1, 5'd0, 5'd1);
        // R3 illegal float sizes
        run_op("R3 f16 no strap", {64'h0, 64'h8000_8000_8000_8000}, 2'b01, 1, 0, 0, 0, 5'd0, 5'd0);
        run_op("R3 f8 illegal", {64'h0, 64'h8080_8080_8080_8080}, 2'b00, 1, 0, 0, 1, 5'd0, 5'd0);
        // R2 size 11 in vector mode
        run_op("R2 int size11", {64'hFFFF, 64'h8000}, 2'b11, 0, 0, 0, 1, 5'd0, 5'd0);
        run_op("R2 float size11", {64'hFFFF, 64'h8000}, 2'b11, 1, 0, 0, 1, 5'd0, 5'd0);
        // R4 quad alignment
        run_op("R4 odd src", '1, 2'b00, 0, 1, 0, 0, 5'd3, 5'd2);
        run_op("R4 odd dst", '1, 2'b01, 0, 1, 0, 0, 5'd2, 5'd7);
        run_op("R4 scalar ignores regs", {64'hDEAD, 64'hC000_0000_BF80_0000}, 2'b10, 0, 1, 1, 0,
               5'd1, 5'd1);
        // R7 upper half dropped without quad
        run_op("R7 upper dropped", {64'h8123_4567_89AB_CDEF, 64'hF0F0_F0F0_0F0F_0F0F},
               2'b00, 0, 0, 0, 0, 5'd1, 5'd1);
        // R8 scalar sizes
        run_op("R8 scalar size00", '1, 2'b00, 1, 0, 1, 1, 5'd0, 5'd0);
        run_op("R8 scalar h no strap", '1, 2'b01, 1, 0, 1, 0, 5'd0, 5'd0);
        run_op("R8 scalar half", '1, 2'b01, 1, 0, 1, 1, 5'd0, 5'd0);
        run_op("R8 scalar double", {64'hFFFF, 64'hFFF8_0000_0000_0001}, 2'b11, 1, 0, 1, 0, 5'd0, 5'd0);

        for (int n = 0; n < 400; n++) begin
            logic [127:0] op;
            logic [1:0]   sz;
            logic         flt, quad, scal, fp16;
            logic [RW-1:0] s, d;
            string        tag;
            op   = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom % 4 == 0) op[31:0] = 32'h8000_8080;
            sz   = 2'($urandom % 4);
            flt  = 1'($urandom % 2);
            quad = 1'($urandom % 2);
            scal = ($urandom % 5 == 0);
            fp16 = 1'($urandom % 2);
            s    = RW'($urandom);
            d    = ($urandom % 2 == 0) ? RW'($urandom) & ~RW'(1) : RW'($urandom);
            if (ref_undef(sz, flt, quad, scal, fp16, s, d)) tag = "R9 rand illegal";
            else if (scal) tag = "R8 rand scalar";
            else if (flt) tag = "R6 rand float";
            else tag = "R5 rand int";
            run_op(tag, op, sz, flt, quad, scal, fp16, s, d);
        end

        // R1 back-to-back requests keep a one-cycle strobe per request
        @(negedge clk);
        in_valid = 1'b1; in_scalar = 1'b0; in_float = 1'b0; in_quad = 1'b0;
        in_size = 2'b00; in_opnd = {64'h0, 64'h0000_0000_0000_00FF};
        @(negedge clk);
        check("R1 back2back first", {out_valid, out_result[126:0]}, {1'b1, 127'h01});
        in_opnd = {64'h0, 64'h0000_0000_0000_0080};
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 back2back second", {out_valid, out_result[126:0]}, {1'b1, 127'h80});
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule